// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the front end of a small 8-bit processor. It reads the bytes of one instruction at a time from a byte-wide synchronous memory, addressed by a 16-bit program counter. The first byte is the opcode and goes into a hidden instruction register. An external decoder looks at that opcode and returns the instruction length (1, 2 or 3 bytes). Any operand bytes then go into two hidden byte registers: a low register for the second byte and a high register for the third.

Once every byte of the instruction is in place, the block raises an instruction-ready flag. It then waits, fetching nothing, until the execution stage reports either completion or a halt. While it waits, execution may ask for the high:low operand pair to drive the memory address, so that a direct load or store can reach its data location. The program counter stays frozen during that time. A halt report stops fetching for good, and only reset clears it.

Top module: `ifseq_top`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the program counter loads `start_addr`, `instr_ready` is 0 and `halted` is 0. In the first cycle after reset is released, `mem_addr` equals `start_addr`.
- R2: Each byte costs two cycles: an address cycle, in which `mem_addr` equals the program counter, and then a capture cycle one cycle later, in which the byte is taken from `mem_rdata`. The program counter rises by exactly one at the end of each address cycle. After an instruction of N bytes it has advanced by N.
- R3: The opcode byte is loaded into `ir_q`. The length on `len_in` is sampled in the opcode capture cycle. A 1-byte instruction raises `instr_ready` two cycles after its opcode address cycle.
- R4: For length 3, the second byte is loaded into `z_q` (low) and the third into `w_q` (high). `instr_ready` rises six cycles after the opcode address cycle.
- R5: For length 2, the second byte is loaded into `z_q` and `w_q` keeps its previous value. `instr_ready` rises four cycles after the opcode address cycle.
- R6: A length code of 0 is treated as length 1.
- R7: While `instr_ready` is 1 and neither `exec_done` nor `exec_halt` is asserted, no fetch starts: `instr_ready` stays 1 and the program counter holds. When `exec_done` is asserted, the next cycle is the address cycle of the following opcode.
- R8: While `instr_ready` is 1 and `use_wz` is 1, `mem_addr` equals `{w_q, z_q}`. Whenever that is not the case, `mem_addr` equals the program counter.
- R9: When `exec_halt` is asserted during `instr_ready`, `halted` is 1 from the next cycle onward and takes priority over a simultaneous `exec_done`. `instr_ready` then stays 0, and the program counter and `mem_addr` stop changing until reset.
- R10: `ir_q`, `z_q` and `w_q` stay constant for as long as `instr_ready` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_addr | input | 16 | Program counter value loaded at reset |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, one cycle after its address |
| len_in | input | 2 | Instruction length from the external decoder |
| exec_done | input | 1 | Execution of the current instruction is complete |
| exec_halt | input | 1 | The current instruction halts the processor |
| use_wz | input | 1 | Execution requests the high:low operand pair as the address |
| instr_ready | output | 1 | A complete instruction is held for execution |
| halted | output | 1 | Fetching has stopped until reset |
| pc_q | output | 16 | Current program counter |
| ir_q | output | 8 | Captured opcode |
| z_q | output | 8 | Low operand byte |
| w_q | output | 8 | High operand byte |

## Verification
Counting from the opcode address cycle, `instr_ready` is due after exactly twice the instruction length in cycles: 2, 4 or 6. Each scenario starts counting at the cycle where `mem_addr` shows the new program counter and compares the cycle on which the flag rises against that figure. The captured bytes and the advanced program counter are read in that same ready cycle. A response to `exec_done` or `exec_halt` is due one edge later, and the address mux answers `use_wz` in the same cycle. Inputs change at the falling edge, and outputs are sampled at the next falling edge or shortly after a combinational change.

// File: rtl/ifseq_pkg.sv
package ifseq_pkg;

   typedef enum logic [2:0] {
      ST_OP_ADR = 3'd0,
      ST_OP_CAP = 3'd1,
      ST_LO_ADR = 3'd2,
      ST_LO_CAP = 3'd3,
      ST_HI_ADR = 3'd4,
      ST_HI_CAP = 3'd5,
      ST_EXEC   = 3'd6,
      ST_HALT   = 3'd7
   } seq_state_e;

   // slot indices of the capture bank
   localparam int SLOT_IR = 0;
   localparam int SLOT_Z  = 1;
   localparam int SLOT_W  = 2;
   localparam int N_SLOTS = 3;

   // a zero length code falls back to a single byte
   function automatic logic [1:0] norm_len(input logic [1:0] raw);
      return (raw == 2'd0) ? 2'd1 : raw;
   endfunction

   function automatic logic is_addr_state(input seq_state_e s);
      return (s == ST_OP_ADR) || (s == ST_LO_ADR) || (s == ST_HI_ADR);
   endfunction

endpackage

// File: rtl/ifseq_pc.sv
module ifseq_pc #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              inc,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc <= start_addr;
      else if (inc) pc <= pc + STEP;
   end

endmodule

// File: rtl/ifseq_capture.sv
module ifseq_capture #(
   parameter int DATA_W  = 8,
   parameter int N_SLOTS = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_SLOTS-1:0]             cap_en,
   input  logic [DATA_W-1:0]              din,
   output logic [N_SLOTS-1:0][DATA_W-1:0] slot_q
);

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         slot_q[g] <= '0;
         else if (cap_en[g]) slot_q[g] <= din;
      end
   end

endmodule

// File: rtl/ifseq_ctrl.sv
module ifseq_ctrl
   import ifseq_pkg::*;
#(
   parameter int LEN_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEN_W-1:0]   len_in,
   input  logic               exec_done,
   input  logic               exec_halt,
   output logic               pc_inc,
   output logic [N_SLOTS-1:0] cap_en,
   output logic               ready,
   output logic               stopped
);

   seq_state_e state_q, state_d;
   logic [1:0] len_q, len_d, len_now;

   assign len_now = norm_len(len_in[1:0]);

   always_comb begin
      state_d = state_q;
      len_d   = len_q;
      unique case (state_q)
         ST_OP_ADR: state_d = ST_OP_CAP;
         ST_OP_CAP: begin
            len_d   = len_now;
            state_d = (len_now == 2'd1) ? ST_EXEC : ST_LO_ADR;
         end
         ST_LO_ADR: state_d = ST_LO_CAP;
         ST_LO_CAP: state_d = (len_q == 2'd2) ? ST_EXEC : ST_HI_ADR;
         ST_HI_ADR: state_d = ST_HI_CAP;
         ST_HI_CAP: state_d = ST_EXEC;
         ST_EXEC: begin
            if (exec_halt)      state_d = ST_HALT;
            else if (exec_done) state_d = ST_OP_ADR;
         end
         ST_HALT:   state_d = ST_HALT;
         default:   state_d = ST_OP_ADR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OP_ADR;
         len_q   <= 2'd1;
      end else begin
         state_q <= state_d;
         len_q   <= len_d;
      end
   end

   assign pc_inc           = is_addr_state(state_q);
   assign cap_en[SLOT_IR]  = (state_q == ST_OP_CAP);
   assign cap_en[SLOT_Z]   = (state_q == ST_LO_CAP);
   assign cap_en[SLOT_W]   = (state_q == ST_HI_CAP);
   assign ready            = (state_q == ST_EXEC);
   assign stopped          = (state_q == ST_HALT);

endmodule

// File: rtl/ifseq_top.sv
module ifseq_top
   import ifseq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 2,
   localparam int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              exec_done,
   input  logic              exec_halt,
   input  logic              use_wz,
   output logic              instr_ready,
   output logic              halted,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] ir_q,
   output logic [DATA_W-1:0] z_q,
   output logic [DATA_W-1:0] w_q
);

   if (LEN_W != 2) begin : g_bad_len
      $error("ifseq_top: LEN_W must be 2 to code lengths 1 to 3");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("ifseq_top: DATA_W too small for an opcode byte");
   end

   logic                           pc_inc;
   logic [N_SLOTS-1:0]             cap_en;
   logic [N_SLOTS-1:0][DATA_W-1:0] slots;

   ifseq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_in    (len_in),
      .exec_done (exec_done),
      .exec_halt (exec_halt),
      .pc_inc    (pc_inc),
      .cap_en    (cap_en),
      .ready     (instr_ready),
      .stopped   (halted)
   );

   ifseq_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_addr),
      .inc        (pc_inc),
      .pc         (pc_q)
   );

   ifseq_capture #(.DATA_W(DATA_W), .N_SLOTS(N_SLOTS)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .din    (mem_rdata),
      .slot_q (slots)
   );

   assign ir_q = slots[SLOT_IR];
   assign z_q  = slots[SLOT_Z];
   assign w_q  = slots[SLOT_W];

   // execution may borrow the operand pair as a data address
   assign mem_addr = (instr_ready && use_wz) ? {w_q, z_q} : pc_q;

endmodule

// File: rtl/ifseq_checker.sv
module ifseq_checker #(
   parameter int DATA_W = 8,
   localparam int ADDR_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] pc_q,
   input logic [DATA_W-1:0] ir_q,
   input logic [DATA_W-1:0] z_q,
   input logic [DATA_W-1:0] w_q,
   input logic              instr_ready,
   input logic              halted,
   input logic              exec_done,
   input logic              exec_halt,
   input logic              use_wz
);

   a_r2_pc_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q != $past(pc_q)) |-> ((pc_q - $past(pc_q)) == ADDR_W'(1)));

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_ready && !exec_done && !exec_halt) |=> (instr_ready && $stable(pc_q)));

   a_r8_wz_address: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_ready && use_wz) |-> (mem_addr == {w_q, z_q}));

   a_r9_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_ready && exec_halt) |=> halted);

   a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && !instr_ready && $stable(pc_q) && $stable(mem_addr)));

   a_r10_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_ready && $past(instr_ready)) |-> ($stable(ir_q) && $stable(z_q) && $stable(w_q)));

endmodule

bind ifseq_top ifseq_checker #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_addr    (mem_addr),
   .pc_q        (pc_q),
   .ir_q        (ir_q),
   .z_q         (z_q),
   .w_q         (w_q),
   .instr_ready (instr_ready),
   .halted      (halted),
   .exec_done   (exec_done),
   .exec_halt   (exec_halt),
   .use_wz      (use_wz)
);

// File: tb/ifseq_top_bench.sv
module ifseq_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] start_addr = 16'h1040;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic [1:0]  len_in;
   logic        exec_done = 1'b0;
   logic        exec_halt = 1'b0;
   logic        use_wz = 1'b0;
   logic        instr_ready, halted;
   logic [15:0] pc_q;
   logic [7:0]  ir_q, z_q, w_q;

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] mem [0:255];

   always #10 clk = ~clk;

   // synchronous memory: one cycle of read latency
   always @(posedge clk) mem_rdata <= mem[mem_addr[7:0]];

   // decoder model: length from the byte on the read data bus
   function automatic logic [1:0] len_of(input logic [7:0] b);
      case (b)
         8'h3A, 8'h32: return 2'd3;
         8'h3E:        return 2'd2;
         8'hFF:        return 2'd0;
         default:      return 2'd1;
      endcase
   endfunction
   assign len_in = len_of(mem_rdata);

   ifseq_top u_ifseq_top (
      .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .len_in(len_in), .exec_done(exec_done),
      .exec_halt(exec_halt), .use_wz(use_wz), .instr_ready(instr_ready),
      .halted(halted), .pc_q(pc_q), .ir_q(ir_q), .z_q(z_q), .w_q(w_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // entered at the falling edge of the opcode address cycle
   task automatic fetch_one(input string tag_len, input logic [15:0] at,
                            input int nbytes, input logic [7:0] e_ir,
                            input logic [7:0] e_z, input logic [7:0] e_w);
      int n = 0;
      chk("R2 opcode address", mem_addr, at);
      while (!instr_ready && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(tag_len, n, 2 * nbytes);
      chk("R3 opcode captured", ir_q, e_ir);
      chk("R4 low operand", z_q, e_z);
      chk("R5 high operand", w_q, e_w);
      chk("R2 pc advanced", pc_q, at + 16'(nbytes));
   endtask

   task automatic stall_check(input int cycles);
      logic [15:0] p = pc_q;
      logic [7:0]  i = ir_q;
      logic [7:0]  z = z_q;
      logic [7:0]  w = w_q;
      repeat (cycles) @(negedge clk);
      chk("R7 ready held", instr_ready, 1'b1);
      chk("R7 pc frozen", pc_q, p);
      chk("R8 pc on address", mem_addr, p);
      chk("R10 regs frozen", {ir_q, z_q, w_q}, {i, z, w});
   endtask

   task automatic wz_check();
      use_wz = 1'b1;
      #2;
      chk("R8 operand address", mem_addr, {w_q, z_q});
      use_wz = 1'b0;
      #2;
      chk("R8 pc address restored", mem_addr, pc_q);
   endtask

   task automatic finish_exec();
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
   endtask

   task automatic do_reset(input logic [15:0] sa);
      rst_n = 1'b0;
      start_addr = sa;
      repeat (2) @(negedge clk);
      chk("R1 reset pc", pc_q, sa);
      chk("R1 reset ready", instr_ready, 1'b0);
      chk("R1 reset halted", halted, 1'b0);
      rst_n = 1'b1;
      chk("R1 first address", mem_addr, sa);
   endtask

   task automatic test_program();
      fetch_one("R4 ready after 6", 16'h1040, 3, 8'h3A, 8'h40, 8'hF8);
      wz_check();
      stall_check(6);
      finish_exec();
      fetch_one("R3 ready after 2", 16'h1043, 1, 8'h2F, 8'h40, 8'hF8);
      finish_exec();
      fetch_one("R5 ready after 4", 16'h1044, 2, 8'h3E, 8'h55, 8'hF8);
      stall_check(3);
      finish_exec();
      fetch_one("R6 zero length as 1", 16'h1046, 1, 8'hFF, 8'h55, 8'hF8);
      finish_exec();
      fetch_one("R4 second long op", 16'h1047, 3, 8'h32, 8'h50, 8'hF8);
      wz_check();
      finish_exec();
   endtask

   task automatic test_halt();
      fetch_one("R3 halt opcode", 16'h104A, 1, 8'h76, 8'h50, 8'hF8);
      exec_halt = 1'b1;
      exec_done = 1'b1;
      @(negedge clk);
      exec_halt = 1'b0;
      exec_done = 1'b0;
      chk("R9 halted over done", halted, 1'b1);
      chk("R9 ready dropped", instr_ready, 1'b0);
      exec_done = 1'b1;
      repeat (8) @(negedge clk);
      exec_done = 1'b0;
      chk("R9 still halted", halted, 1'b1);
      chk("R9 pc stopped", pc_q, 16'h104B);
      chk("R9 address stopped", mem_addr, 16'h104B);
      chk("R9 no ready", instr_ready, 1'b0);
   endtask

   task automatic test_restart();
      do_reset(16'h1080);
      fetch_one("R3 after restart", 16'h1080, 1, 8'h3C, 8'h00, 8'h00);
      finish_exec();
      chk("R7 next fetch address", mem_addr, 16'h1081);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      for (int k = 0; k < 256; k++) mem[k] = 8'h00;
      mem[8'h40] = 8'h3A; mem[8'h41] = 8'h40; mem[8'h42] = 8'hF8;
      mem[8'h43] = 8'h2F;
      mem[8'h44] = 8'h3E; mem[8'h45] = 8'h55;
      mem[8'h46] = 8'hFF;
      mem[8'h47] = 8'h32; mem[8'h48] = 8'h50; mem[8'h49] = 8'hF8;
      mem[8'h4A] = 8'h76;
      mem[8'h80] = 8'h3C;
      @(negedge clk);
      do_reset(16'h1040);
      test_program();
      test_halt();
      test_restart();
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

endmodule